// File: doc/BRIEF.md
# MII Transmit FCS Appender with Underflow Poisoning

This block takes a transmit frame as a byte stream from an internal buffer and puts it on an MII transmit interface as 4-bit nibbles, one nibble per transmit clock. It keeps a running Ethernet CRC-32 over every byte it accepts and, after the last byte, appends the 32-bit frame check sequence. The block runs entirely in the transmit clock domain supplied by the PHY (2.5 MHz at 10 Mbps, 25 MHz at 100 Mbps), so each clock carries exactly one nibble. Preamble and start delimiter are added elsewhere.

The MII side has only data and enable; there is no transmit error output. If the buffer cannot supply the next byte in time (transmit underflow), the block stops taking data at once and closes the frame with the bitwise inverse of the correct FCS over the bytes actually sent. Any receiver then drops the frame as a CRC error. A one-cycle done pulse marks the end of every frame, and a one-cycle underflow pulse comes with it when the frame was poisoned.

The byte input is valid/ready. `s_ready` rises only when the block can take a byte: when idle with the interframe gap over, and during the second nibble of a byte that was not marked last. Inside a frame the source must not stall. If `s_valid` is low while `s_ready` is high and a frame is in progress, that is an underflow. Between frames the source may hold `s_valid` high for as long as it likes, and the byte waits.

Top module: `mii_tx_fcs_poison`

## Requirements
- R1: The FCS is the IEEE 802.3 CRC-32: reflected polynomial 0xEDB88320, register preset to all ones before the first byte, each byte fed least significant bit first, and the final register complemented. For the nine ASCII bytes "123456789" the FCS is 0xCBF43926.
- R2: Each accepted byte goes out on `txd` as bits [3:0] in one cycle and bits [7:4] in the next, with `tx_en` high for every data and FCS nibble. While `tx_en` is low, `txd` is 0. No transmit error pin exists.
- R3: The 32-bit FCS follows the last data nibble as eight nibbles: bits [3:0] first, then [7:4], and so on up to bits [31:28] (lowest byte first, low nibble first).
- R4: A byte is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high when idle (after the gap) and in the high-nibble cycle of a byte not marked `s_last`. A frame of N bytes that is not poisoned occupies exactly 2N+8 consecutive `tx_en` cycles.
- R5: A frame that has started, whose last accepted byte was not marked last, underflows if `s_valid` is low in a cycle where `s_ready` is high. The block then sends the FCS nibbles at once, with the value equal to the bitwise inverse of the correct FCS over the bytes sent (the uncomplemented register). Such a frame of k bytes occupies 2k+8 `tx_en` cycles.
- R6: Once the last byte is taken or an underflow occurs, no byte is accepted until the gap has ended. Bytes offered in that time are not sent.
- R7: `frame_done` is high for exactly one cycle: the first cycle with `tx_en` low after the final FCS nibble. It is low at all other times.
- R8: `underflow` pulses in the same cycle as `frame_done`, and only for a frame that underflowed.
- R9: Between frames, `tx_en` stays low for at least IFG_NIBBLES (24) cycles. If the next byte is already waiting, the gap is exactly 24 cycles.
- R10: During and right after reset, `tx_en`, `txd`, `frame_done` and `underflow` are all 0, and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied transmit clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 8 | Frame byte from the buffer |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | Marks the final byte of the frame |
| s_ready | output | 1 | Block accepts a byte this cycle |
| txd | output | 4 | MII transmit nibble |
| tx_en | output | 1 | MII transmit enable |
| frame_done | output | 1 | One-cycle pulse after the last FCS nibble |
| underflow | output | 1 | One-cycle pulse with `frame_done` for a poisoned frame |

## Verification
A wrong CRC register shows up in the eight FCS nibbles of the frame it affects, no earlier. The scoreboard therefore computes the expected FCS bit-serially for every frame and also checks it against the known check value. A fault in the nibble phase or the byte latch corrupts `txd` within two cycles of the byte being taken. A fault in the underflow decision or the last-byte flag changes the `tx_en` length of that frame and the pulse pair at its end. A gap counter that is off by one is caught at the next frame start, because the bench keeps a byte waiting and expects exactly 24 low cycles.

// File: rtl/mii_txp_pkg.sv
package mii_txp_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_FCS  = 3'd3,
    ST_GAP  = 3'd4
  } txp_state_e;

  // Advance a reflected CRC-32 register over one byte, LSB first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] cur,
                                                     input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] r;
    r = cur ^ {{(CRC_W-BYTE_W){1'b0}}, din};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/mii_txp_crc.sv
module mii_txp_crc
  import mii_txp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_PRESET;
    end else if (start) begin
      crc_q <= crc_step_byte(CRC_PRESET, din);
    end else if (step) begin
      crc_q <= crc_step_byte(crc_q, din);
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/mii_txp_fcs_seq.sv
module mii_txp_fcs_seq #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              advance,
  output logic [NIB_W-1:0]  nib_o,
  output logic              last_o
);

  localparam int unsigned NIBS  = WORD_W / NIB_W;
  localparam int unsigned CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NIBS - 1);

  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= word_in;
      idx_q  <= '0;
    end else if (advance) begin
      word_q <= word_q >> NIB_W;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign nib_o  = word_q[NIB_W-1:0];
  assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/mii_txp_gap.sv
module mii_txp_gap #(
  parameter int unsigned IFG_NIBBLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  // The gap state lasts LOAD+1 cycles; the accepting idle cycle adds one more.
  localparam int unsigned LOAD  = IFG_NIBBLES - 2;
  localparam int unsigned CNT_W = $clog2(IFG_NIBBLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(LOAD);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/mii_tx_fcs_poison.sv
module mii_tx_fcs_poison
  import mii_txp_pkg::*;
#(
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned IFG_NIBBLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic [NIB_W-1:0]  txd,
  output logic              tx_en,
  output logic              frame_done,
  output logic              underflow
);

  txp_state_e        state_q, state_d;
  logic [BYTE_W-1:0] byte_q;
  logic              last_q;
  logic              poison_q;
  logic              done_q;
  logic              uf_q;

  logic              accept;
  logic              crc_start, crc_step;
  logic [CRC_W-1:0]  crc_val;
  logic              fcs_load;
  logic [CRC_W-1:0]  fcs_word;
  logic [NIB_W-1:0]  fcs_nib;
  logic              fcs_last;
  logic              gap_start, gap_busy;

  assign s_ready   = (state_q == ST_IDLE) || ((state_q == ST_HI) && !last_q);
  assign accept    = s_valid && s_ready;
  assign crc_start = accept && (state_q == ST_IDLE);
  assign crc_step  = accept && (state_q == ST_HI);
  // Frame closes on the last byte or on a stalled source.
  assign fcs_load  = (state_q == ST_HI) && (last_q || !s_valid);
  assign fcs_word  = last_q ? ~crc_val : crc_val;
  assign gap_start = (state_q == ST_FCS) && fcs_last;

  mii_txp_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (crc_start),
    .step  (crc_step),
    .din   (s_data),
    .crc_o (crc_val)
  );

  mii_txp_fcs_seq #(
    .WORD_W (CRC_W),
    .NIB_W  (NIB_W)
  ) u_fcs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fcs_load),
    .word_in (fcs_word),
    .advance (state_q == ST_FCS),
    .nib_o   (fcs_nib),
    .last_o  (fcs_last)
  );

  mii_txp_gap #(
    .IFG_NIBBLES (IFG_NIBBLES)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (gap_start),
    .busy  (gap_busy)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_LO;
      ST_LO:                  state_d = ST_HI;
      ST_HI:   if (fcs_load)  state_d = ST_FCS;
               else           state_d = ST_LO;
      ST_FCS:  if (fcs_last)  state_d = ST_GAP;
      ST_GAP:  if (!gap_busy) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      byte_q   <= '0;
      last_q   <= 1'b0;
      poison_q <= 1'b0;
      done_q   <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        byte_q <= s_data;
        last_q <= s_last;
      end
      if (fcs_load) poison_q <= !last_q;
      done_q <= gap_start;
      uf_q   <= gap_start && poison_q;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_LO:   txd = byte_q[NIB_W-1:0];
      ST_HI:   txd = byte_q[2*NIB_W-1:NIB_W];
      ST_FCS:  txd = fcs_nib;
      default: txd = '0;
    endcase
  end

  assign tx_en      = (state_q == ST_LO) || (state_q == ST_HI) || (state_q == ST_FCS);
  assign frame_done = done_q;
  assign underflow  = uf_q;

endmodule

// File: rtl/mii_txp_chk.sv
module mii_txp_chk #(
  parameter int unsigned IFG_NIBBLES = 24
) (
  input logic clk,
  input logic rst_n,
  input logic s_ready,
  input logic tx_en,
  input logic frame_done,
  input logic underflow
);

  localparam int unsigned LW = $clog2(IFG_NIBBLES + 1);

  logic [LW-1:0] low_cnt;
  logic          seen_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      seen_frame <= 1'b0;
    end else if (tx_en) begin
      low_cnt    <= '0;
      seen_frame <= 1'b1;
    end else if (low_cnt < LW'(IFG_NIBBLES)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!tx_en && $past(tx_en)));

  // R8
  uf_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> frame_done);

  // R9
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && seen_frame) |-> (low_cnt >= LW'(IFG_NIBBLES)));

  // R5
  no_gap_midframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && tx_en) |=> tx_en);

endmodule

bind mii_tx_fcs_poison mii_txp_chk #(.IFG_NIBBLES(IFG_NIBBLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_ready    (s_ready),
  .tx_en      (tx_en),
  .frame_done (frame_done),
  .underflow  (underflow)
);

// File: tb/mii_tx_fcs_poison_tb.sv
module mii_tx_fcs_poison_tb;

  localparam int IFG = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [3:0] txd;
  logic       tx_en;
  logic       frame_done;
  logic       underflow;

  always #4 clk = ~clk;

  mii_tx_fcs_poison #(.NIB_W(4), .IFG_NIBBLES(IFG)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_data     (s_data),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_ready    (s_ready),
    .txd        (txd),
    .tx_en      (tx_en),
    .frame_done (frame_done),
    .underflow  (underflow)
  );

  logic [3:0] exp_nib_q[$];
  int         exp_len_q[$];
  bit         exp_uf_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         mon_on = 1'b0;
  bit         timed_out = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bit-serial reference register (no final complement).
  function automatic logic [31:0] ref_reg(input logic [7:0] d[], input int n);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[0] ^ d[k][b];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r;
  endfunction

  // Driver: n_sent < d.size() makes the source stall after n_sent bytes.
  task automatic send_frame(input logic [7:0] d[], input int n_sent,
                            input bit use_const, input logic [31:0] const_fcs);
    bit          uf;
    logic [31:0] fcs;
    uf  = (n_sent < d.size());
    fcs = uf ? ref_reg(d, n_sent) : ~ref_reg(d, n_sent);
    if (use_const) fcs = const_fcs;
    for (int k = 0; k < n_sent; k++) begin
      exp_nib_q.push_back(d[k][3:0]);
      exp_nib_q.push_back(d[k][7:4]);
    end
    for (int k = 0; k < 8; k++) exp_nib_q.push_back(fcs[4*k +: 4]);
    exp_len_q.push_back(2 * n_sent + 8);
    exp_uf_q.push_back(uf);
    for (int k = 0; k < n_sent; k++) begin
      s_data  = d[k];
      s_valid = 1'b1;
      s_last  = (!uf && (k == n_sent - 1));
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    if (uf) begin
      s_valid = 1'b0;
      s_last  = 1'b0;
      repeat (2) @(negedge clk);
      // Junk offered during the poisoned FCS must not be taken (R6).
      s_data  = 8'hA5;
      s_valid = 1'b1;
      while (!frame_done) @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard.
  bit         in_frame = 1'b0;
  bit         gap_on = 1'b0;
  int         nib_cnt = 0;
  int         low_run = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_en) begin
        if (!in_frame) begin
          if (gap_on) chk(low_run == IFG, "R9", "gap length", low_run, IFG);
          in_frame = 1'b1;
          nib_cnt  = 0;
        end
        if (exp_nib_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected nibble", {28'h0, txd}, 32'h0);
        end else begin
          logic [3:0] e;
          e = exp_nib_q.pop_front();
          chk(txd == e, "R1 R2 R3 R5", "txd nibble", {28'h0, txd}, {28'h0, e});
        end
        nib_cnt++;
      end else begin
        chk(txd == 4'h0, "R2", "txd idle", {28'h0, txd}, 32'h0);
        if (in_frame) begin
          bit e_uf;
          int e_len;
          e_uf  = (exp_uf_q.size() != 0) ? exp_uf_q.pop_front() : 1'b0;
          e_len = (exp_len_q.size() != 0) ? exp_len_q.pop_front() : -1;
          chk(frame_done == 1'b1, "R7", "done pulse", frame_done, 1);
          chk(underflow == e_uf, "R8", "underflow pulse", underflow, e_uf);
          chk(nib_cnt == e_len, "R4 R5", "frame length", nib_cnt, e_len);
          in_frame = 1'b0;
          gap_on   = 1'b1;
          low_run  = 1;
        end else begin
          chk(!frame_done && !underflow, "R7 R8", "stray pulse",
              {30'h0, frame_done, underflow}, 32'h0);
          low_run++;
        end
      end
    end
  end

  task automatic run_tests;
    logic [7:0] d[];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk(tx_en == 1'b0, "R10", "tx_en after reset", tx_en, 0);
    chk(txd == 4'h0, "R10", "txd after reset", txd, 0);
    chk(frame_done == 1'b0 && underflow == 1'b0, "R10", "pulses after reset",
        {30'h0, frame_done, underflow}, 0);
    chk(s_ready == 1'b1, "R10", "ready after reset", s_ready, 1);
    mon_on = 1'b1;

    // R1: check string against its known FCS
    d = new[9];
    foreach (d[k]) d[k] = 8'h31 + 8'(k);
    send_frame(d, 9, 1'b1, 32'hCBF43926);

    // Single-byte frame
    d = new[1];
    d[0] = 8'h00;
    send_frame(d, 1, 1'b0, 32'h0);

    // 64-byte frame, back to back
    d = new[64];
    foreach (d[k]) d[k] = 8'(k * 7 + 3);
    send_frame(d, 64, 1'b0, 32'h0);

    // R5: underflow after 5 of 20 bytes
    d = new[20];
    foreach (d[k]) d[k] = 8'(8'hC3 ^ k);
    send_frame(d, 5, 1'b0, 32'h0);

    // R5: underflow right after the first byte
    d = new[10];
    foreach (d[k]) d[k] = 8'(k + 8'h40);
    send_frame(d, 1, 1'b0, 32'h0);

    // All-ones payload
    d = new[30];
    foreach (d[k]) d[k] = 8'hFF;
    send_frame(d, 30, 1'b0, 32'h0);

    // R5: last byte never offered
    d = new[64];
    foreach (d[k]) d[k] = 8'(k * 13);
    send_frame(d, 63, 1'b0, 32'h0);

    s_valid = 1'b0;
    s_last  = 1'b0;
    repeat (200) @(negedge clk);
    chk(exp_nib_q.size() == 0, "R4", "leftover expected nibbles", exp_nib_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule